// File: doc/BRIEF.md
# Programmable Local Interrupt Timer

A down-counting timer that raises an interrupt request carrying a programmable vector. Software writes four small registers through a single write port: a divide configuration, an initial count, a timer control entry (vector, mask, periodic flag) and a software enable. A free-running prescaler produces a tick enable at the selected rate, and the counter decrements once per tick. The count can be read at any time on a dedicated output.

When the count expires, an internal pending-expiry counter is incremented. The interrupt request is a level that stays high while expiries are pending and the entry is unmasked. Each pulse of the accept input while the request is high consumes one pending expiry. In one-shot mode the count parks at zero after expiry. In periodic mode it reloads from the initial count. Clearing the software enable masks the entry and discards every pending expiry.

Top module: `prog_irq_timer`

## Requirements
- R1: The divide ratio is 2^k with k = ({cfg[3], cfg[1:0]} + 1) mod 8. Bit 2 of the configuration is ignored, so 4'b1011 divides by 1 and the other codes divide by 2 to 128. A divide write (select 0) clears the prescaler and leaves the count unchanged.
- R2: A write to the initial count (select 1) loads the count with the written value in the same edge and clears the prescaler. m cycles later the count reads N - floor(m/D), until it expires.
- R3: An initial count of 0 stops the timer. The count reads 0 and no expiry is produced.
- R4: In one-shot mode (entry bit 17 = 0) the count drops from 1 to 0 on a tick, which is one expiry. It then stays 0 until the initial count is rewritten.
- R5: In periodic mode (entry bit 17 = 1) the tick that would bring the count to 0 reloads the initial count instead. This gives one expiry every N ticks.
- R6: Each expiry increments a pending counter that saturates at 2^PEND_W - 1.
- R7: irqReq is high exactly while the pending count is nonzero and the entry mask is clear. irqVector always shows the entry's vector.
- R8: A cycle with irqAccept and irqReq both high removes one pending expiry. An accept while irqReq is low is ignored.
- R9: The control entry (select 2) keeps only the vector (bits 7:0), the mask (bit 16) and the periodic flag (bit 17). Other bits are dropped.
- R10: An entry write while the software enable is clear stores the mask bit as set, whatever value was written.
- R11: Writing the software enable (select 3, bit 0) as 0 sets the entry mask and clears the pending count.
- R12: After reset the entry is masked with vector 0 and one-shot mode. The divide configuration, initial count, count and pending count are 0, and the software enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 divide, 1 initial count, 2 control entry, 3 software enable |
| wrData | input | 32 | Write data |
| irqAccept | input | 1 | Pulse consuming one pending expiry |
| curCount | output | CNT_W | Current count |
| irqReq | output | 1 | Interrupt request level |
| irqVector | output | 8 | Vector of the request |

## Verification
The bench builds the block with CNT_W = 16 and PEND_W = 3. A pending counter of three bits fills in seven expiries, so saturation and the full drain through seven accepts fit in a short run. A wrap-around of the pending count on an accept without a request also shows up as a missing or extra request. A 16-bit count keeps every divide code, including divide-by-128, observable within a few hundred cycles.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int PRESC_W = 7;
  localparam int DIVEXP_W = 3;

  typedef enum logic [1:0] {
    SEL_DIV   = 2'd0,
    SEL_INIT  = 2'd1,
    SEL_ENTRY = 2'd2,
    SEL_EN    = 2'd3
  } regSel_e;

  typedef struct packed {
    logic                restart;
    logic                presClr;
    logic                periodic;
    logic [DIVEXP_W-1:0] divExp;
  } tmrCtl_t;
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [31:0]      wrData,
  input  logic             expire,
  input  logic             irqAccept,
  output tmrCtl_t          ctl,
  output logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] initVal,
  output logic             irqReq,
  output logic [7:0]       irqVector
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [3:0]        divCfg;
  logic [CNT_W-1:0]  initCount;
  logic [7:0]        vecR;
  logic              maskR;
  logic              periodicR;
  logic              swEn;
  logic [PEND_W-1:0] pend;

  logic wrDiv, wrInit, wrEntry, wrEnable, disWr, consume;

  assign wrDiv    = wrEn && (wrSel == SEL_DIV);
  assign wrInit   = wrEn && (wrSel == SEL_INIT);
  assign wrEntry  = wrEn && (wrSel == SEL_ENTRY);
  assign wrEnable = wrEn && (wrSel == SEL_EN);
  assign disWr    = wrEnable && !wrData[0];
  assign consume  = irqAccept && irqReq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCfg    <= '0;
      initCount <= '0;
      vecR      <= '0;
      maskR     <= 1'b1;
      periodicR <= 1'b0;
      swEn      <= 1'b0;
    end else begin
      if (wrDiv)  divCfg    <= wrData[3:0];
      if (wrInit) initCount <= wrData[CNT_W-1:0];
      if (wrEntry) begin
        vecR      <= wrData[7:0];
        maskR     <= wrData[16] | ~swEn;
        periodicR <= wrData[17];
      end
      if (wrEnable) begin
        swEn <= wrData[0];
        if (!wrData[0]) maskR <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (disWr) begin
      pend <= '0;
    end else if (expire && !consume) begin
      if (pend != PEND_MAX) pend <= pend + PEND_W'(1);
    end else if (!expire && consume) begin
      pend <= pend - PEND_W'(1);
    end
  end

  always_comb begin
    ctl.restart  = wrInit;
    ctl.presClr  = wrDiv;
    ctl.periodic = periodicR;
    ctl.divExp   = DIVEXP_W'({divCfg[3], divCfg[1:0]} + 3'd1);
  end

  assign loadVal   = wrData[CNT_W-1:0];
  assign initVal   = initCount;
  assign irqReq    = (pend != '0) && !maskR;
  assign irqVector = vecR;

  logic unusedWrBits;
  assign unusedWrBits = ^wrData;

  a_r6_pend_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == PEND_MAX && expire && !consume && !disWr) |=> (pend == PEND_MAX));
  a_r8_accept_takes_one: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !expire && !disWr) |=> (pend == $past(pend) - PEND_W'(1)));
  a_r10_mask_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEntry && !swEn && !wrEnable) |=> maskR);
  a_r11_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    disWr |=> (pend == '0 && maskR && !irqReq));
endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmrCtl_t          ctl,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] initVal,
  output logic             expire,
  output logic [CNT_W-1:0] count
);
  logic [PRESC_W-1:0] presc;
  logic [PRESC_W-1:0] lowMask;
  logic               tick;

  assign lowMask = PRESC_W'((8'd1 << ctl.divExp) - 8'd1);
  assign tick    = !ctl.presClr && ((presc & lowMask) == lowMask);
  assign expire  = tick && !ctl.restart && (count == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      count <= '0;
    end else if (ctl.restart) begin
      presc <= '0;
      count <= loadVal;
    end else begin
      presc <= ctl.presClr ? '0 : presc + PRESC_W'(1);
      if (tick && count != '0) begin
        if (count == CNT_W'(1)) count <= ctl.periodic ? initVal : '0;
        else                    count <= count - CNT_W'(1);
      end
    end
  end

  a_r2_restart_loads: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.restart |=> (count == $past(loadVal) && presc == '0));
  a_r3_zero_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.restart && count == '0) |=> (count == '0));
  a_r4_oneshot_lands_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctl.periodic) |=> (count == '0));
  a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctl.periodic) |=> (count == $past(initVal)));
endmodule

// File: rtl/prog_irq_timer.sv
module prog_irq_timer
  import pit_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [31:0]      wrData,
  input  logic             irqAccept,
  output logic [CNT_W-1:0] curCount,
  output logic             irqReq,
  output logic [7:0]       irqVector
);
  tmrCtl_t          ctl;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] initVal;
  logic             expire;

  pit_ctrl #(.CNT_W(CNT_W), .PEND_W(PEND_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .expire(expire), .irqAccept(irqAccept), .ctl(ctl), .loadVal(loadVal),
    .initVal(initVal), .irqReq(irqReq), .irqVector(irqVector)
  );

  pit_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .loadVal(loadVal),
    .initVal(initVal), .expire(expire), .count(curCount)
  );
endmodule

// File: tb/sim_prog_irq_timer.sv
`timescale 1ns/1ps
module sim_prog_irq_timer;
  localparam int CNT_W  = 16;
  localparam int PEND_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       wrSel = 2'd0;
  logic [31:0]      wrData = '0;
  logic             irqAccept = 1'b0;
  logic [CNT_W-1:0] curCount;
  logic             irqReq;
  logic [7:0]       irqVector;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  prog_irq_timer #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .irqAccept(irqAccept), .curCount(curCount), .irqReq(irqReq), .irqVector(irqVector)
  );

  // row: {divCfg[3:0], initCount[15:0], waitCycles[15:0], expectedCount[15:0]}
  localparam logic [51:0] VEC [10] = '{
    {4'hB, 16'd20, 16'd5,   16'd15},
    {4'h0, 16'd20, 16'd7,   16'd17},
    {4'h1, 16'd10, 16'd9,   16'd8},
    {4'h2, 16'd5,  16'd17,  16'd3},
    {4'h3, 16'd4,  16'd33,  16'd2},
    {4'h8, 16'd3,  16'd64,  16'd1},
    {4'h9, 16'd2,  16'd64,  16'd1},
    {4'hA, 16'd2,  16'd129, 16'd1},
    {4'hB, 16'd3,  16'd10,  16'd0},
    {4'h4, 16'd10, 16'd6,   16'd7}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic accept();
    irqAccept = 1'b1;
    @(posedge clk); @(negedge clk);
    irqAccept = 1'b0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(2'd1, 32'd0);
    wr(2'd3, 32'd0);
    wr(2'd3, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    waitn(3);
    rst_n = 1'b1;
    waitn(1);
    // R12 reset state
    chk("R12 count", 32'(curCount), 0);
    chk("R12 req", 32'(irqReq), 0);
    chk("R12 vector", 32'(irqVector), 0);

    // R1/R2 table of divide codes and counts
    for (int i = 0; i < 10; i++) begin
      wr(2'd0, 32'(VEC[i][51:48]));
      wr(2'd1, 32'(VEC[i][47:32]));
      waitn(int'(VEC[i][31:16]));
      chk($sformatf("R1 R2 R4 row %0d", i), 32'(curCount), 32'(VEC[i][15:0]));
    end
    chk("R10 mask held while disabled", 32'(irqReq), 0);

    // R2 rewrite mid-count restarts
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd10);
    waitn(4);
    chk("R2 mid count", 32'(curCount), 6);
    wr(2'd1, 32'd8);
    chk("R2 reload", 32'(curCount), 8);
    waitn(3);
    chk("R2 after restart", 32'(curCount), 5);

    // R3 zero initial count stops
    quiesce();
    wr(2'd2, 32'h0000_0010);
    wr(2'd1, 32'd5);
    waitn(2);
    wr(2'd1, 32'd0);
    chk("R3 zero reads", 32'(curCount), 0);
    waitn(10);
    chk("R3 still zero", 32'(curCount), 0);
    chk("R3 no expiry", 32'(irqReq), 0);

    // R5/R7/R8 periodic mode
    quiesce();
    wr(2'd2, 32'h0002_0042);
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd4);
    waitn(3);
    chk("R5 count before reload", 32'(curCount), 1);
    waitn(1);
    chk("R5 reload", 32'(curCount), 4);
    chk("R7 req", 32'(irqReq), 1);
    chk("R7 vector", 32'(irqVector), 32'h42);
    accept();
    chk("R8 consumed", 32'(irqReq), 0);
    chk("R5 count", 32'(curCount), 3);
    waitn(3);
    chk("R5 second expiry", 32'(irqReq), 1);
    waitn(4);
    accept();
    chk("R8 one of two left", 32'(irqReq), 1);
    accept();
    chk("R8 drained", 32'(irqReq), 0);

    // R7 mask gates the request
    wr(2'd2, 32'h0003_0042);
    waitn(20);
    chk("R7 masked", 32'(irqReq), 0);
    wr(2'd2, 32'h0002_0042);
    chk("R7 unmasked", 32'(irqReq), 1);

    // R11 software disable
    wr(2'd1, 32'd0);
    chk("R11 pending before", 32'(irqReq), 1);
    wr(2'd3, 32'd0);
    chk("R11 disabled", 32'(irqReq), 0);
    wr(2'd3, 32'd1);
    chk("R11 mask forced", 32'(irqReq), 0);
    wr(2'd2, 32'h0002_0042);
    chk("R11 pending cleared", 32'(irqReq), 0);

    // R10 write while disabled forces mask
    wr(2'd3, 32'd0);
    wr(2'd2, 32'h0000_0055);
    wr(2'd3, 32'd1);
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd2);
    waitn(3);
    chk("R10 forced mask", 32'(irqReq), 0);
    chk("R10 vector kept", 32'(irqVector), 32'h55);
    wr(2'd2, 32'h0000_0055);
    chk("R10 unmask later", 32'(irqReq), 1);

    // R9 extra entry bits dropped; R4 single expiry
    quiesce();
    wr(2'd2, 32'hFFFC_FF33);
    wr(2'd1, 32'd2);
    waitn(5);
    chk("R9 one-shot kept", 32'(curCount), 0);
    chk("R9 vector", 32'(irqVector), 32'h33);
    chk("R9 unmasked", 32'(irqReq), 1);
    accept();
    waitn(5);
    chk("R4 single expiry", 32'(irqReq), 0);

    // R8 accept with no request ignored
    quiesce();
    wr(2'd2, 32'h0000_0021);
    accept();
    chk("R8 idle accept", 32'(irqReq), 0);
    wr(2'd1, 32'd2);
    waitn(2);
    chk("R8 one expiry", 32'(irqReq), 1);
    accept();
    chk("R8 no wrap", 32'(irqReq), 0);

    // R6 saturation
    quiesce();
    wr(2'd2, 32'h0002_0011);
    wr(2'd1, 32'd1);
    waitn(20);
    chk("R5 period one", 32'(curCount), 1);
    wr(2'd1, 32'd0);
    for (int k = 0; k < 7; k++) begin
      chk($sformatf("R6 drain %0d", k), 32'(irqReq), 1);
      accept();
    end
    chk("R6 saturated at seven", 32'(irqReq), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule